// File: doc/BRIEF.md
# Two-Frame AVSBus SPI Master

The block runs one AVSBus read as two back-to-back 32-bit SPI frames under one chip select. A single write strobe latches a 4-bit data type, a 4-bit rail select and a 10-bit clock divider. The block then builds the command word and appends a 3-bit CRC to it. The first frame shifts this word out and captures nothing. After a short idle gap, the second frame drives MOSI low and captures a 32-bit response word from the slave. That word becomes visible in a response register when the frame ends.

The host side has four controls. A busy flag is high while a transaction runs. A sticky error flag records a write strobe that arrives while busy; such a write is otherwise ignored. A clear pulse resets the sticky flag. The SPI side uses clock polarity 0 and clock phase 1: the clock idles low, the master drives data on each rising edge, and both sides sample on each falling edge.

Top module: `avs_frame_master`

## Requirements
- R1: The command word, in LSB-first numbering, holds the following fields. Bits [31:30]=01 and [29:28]=11. Bit [27]=0. Bits [26:23] hold the latched data type and [22:19] the latched rail select. Bits [18:3] are all ones. A status read (data type 1110, rail 1111) therefore gives 0x777FFFF8 before the CRC is added.
- R2: Bits [2:0] of the command word are the remainder of bits [31:3] divided MSB-first by the polynomial x^3+x+1 (divisor 1011).
- R3: MOSI changes only on rising SCLK edges. In frame one it carries the command word MSB first, 32 bits. In frame two it is 0 at every falling edge.
- R4: In frame two, MISO is sampled on each of 32 falling SCLK edges, MSB first. resp_o takes the assembled word in the cycle that frame two ends and holds it at all other times.
- R5: SCLK is low whenever the block is idle. Within a frame, rising edges are (div+1)*8 system clocks apart, where div is the divider latched at the strobe.
- R6: Between the last falling edge of frame one and the first rising edge of frame two, SCLK stays low for exactly (div+1)*12 system clocks.
- R7: busy_o and a low cs_n_o rise together in the cycle after a strobe that is accepted while idle. Both stay up until the end of frame two, and they drop in the same cycle that resp_o updates.
- R8: A strobe while busy sets err_o in the next cycle. It leaves the running transaction's command word unchanged.
- R9: A clear pulse drops err_o in the next cycle. When a strobe-while-busy and a clear pulse arrive in the same cycle, err_o is set.
- R10: After reset: busy_o=0, err_o=0, resp_o=0, cs_n_o=1, sclk_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | 10 | Clock divider, latched at an accepted strobe |
| wr_stb_i | input | 1 | Write strobe that starts a transaction |
| dtype_i | input | 4 | Command data type |
| rail_i | input | 4 | Rail select |
| clr_sticky_i | input | 1 | Clears the sticky error flag |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | Sticky write-while-busy flag |
| resp_o | output | 32 | Last captured response word |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
The sticky flag has two sources that can fall in the same cycle: a strobe while busy sets it and a clear pulse resets it. The bench provokes this collision in the middle of a running transaction. It expects the flag to read set afterwards. It also expects the slave model to have received the first command word unchanged. A second collision is between a strobe and the final falling edge, where the response register is loaded. To judge that case, the bench compares every captured response with the word its slave model served, including transactions that were disturbed by a mid-frame strobe.

// File: rtl/avs_pkg.sv
package avs_pkg;
  localparam int WORD_W = 32;
  localparam int BODY_W = 29;
  localparam int CRC_W  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_GAP, ST_RX} avs_state_e;

  // Serial remainder of body*x^3 modulo x^3+x+1, MSB first.
  function automatic logic [CRC_W-1:0] avs_crc3(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = body[i] ^ r[2];
      r  = {r[1], r[0] ^ fb, fb};
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] avs_cmd_word(input logic [3:0] dtype,
                                                     input logic [3:0] rail);
    logic [BODY_W-1:0] body;
    body = {2'b01, 2'b11, 1'b0, dtype, rail, 16'hFFFF};
    return {body, avs_crc3(body)};
  endfunction
endpackage

// File: rtl/avs_tick_gen.sv
module avs_tick_gen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 3;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  // half period = (div+1)*4 system clocks
  assign half_m1 = {1'b0, div_q, 2'b11};
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/avs_sticky.sv
module avs_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
    else if (clr_i) err_o <= 1'b0;
  end

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> err_o);
  // R9
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !err_o);
endmodule

// File: rtl/avs_frame_seq.sv
module avs_frame_seq
  import avs_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        dtype_i,
  input  logic [3:0]        rail_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic [DIV_W-1:0]  div_q,
  output logic              busy_o,
  output logic              frame_done_o,
  output logic [WORD_W-1:0] resp_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_n_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  avs_state_e        state;
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [BIT_W-1:0]  bit_cnt;
  logic              fall_evt;
  logic              rise_evt;

  assign busy_o       = (state != ST_IDLE);
  assign rise_evt     = tick_i && !sclk_o;
  assign fall_evt     = tick_i && sclk_o;
  assign frame_done_o = (state == ST_RX) && fall_evt && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      resp_o  <= '0;
      div_q   <= '0;
      sclk_o  <= 1'b0;
      mosi_o  <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          tx_sh   <= avs_cmd_word(dtype_i, rail_i);
          div_q   <= div_i;
          bit_cnt <= '0;
          cs_n_o  <= 1'b0;
          state   <= ST_TX;
        end
        ST_TX: if (rise_evt) begin
          sclk_o <= 1'b1;
          mosi_o <= tx_sh[WORD_W-1];
          tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
        end else if (fall_evt) begin
          sclk_o <= 1'b0;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            state   <= ST_GAP;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_GAP: if (tick_i) begin
          if (bit_cnt == BIT_W'(1)) begin
            bit_cnt <= '0;
            state   <= ST_RX;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_RX: if (rise_evt) begin
          sclk_o <= 1'b1;
          mosi_o <= 1'b0;
        end else if (fall_evt) begin
          sclk_o <= 1'b0;
          rx_sh  <= {rx_sh[WORD_W-2:0], miso_i};
          if (bit_cnt == LAST_BIT) begin
            resp_o  <= {rx_sh[WORD_W-2:0], miso_i};
            bit_cnt <= '0;
            cs_n_o  <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |=> $stable(resp_o));
  // R7
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == !cs_n_o);
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);
  // R3
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> $rose(sclk_o));
  // R6
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> !sclk_o);
endmodule

// File: rtl/avs_frame_master.sv
module avs_frame_master
  import avs_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_stb_i,
  input  logic [3:0]        dtype_i,
  input  logic [3:0]        rail_i,
  input  logic              clr_sticky_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [WORD_W-1:0] resp_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_n_o
);
  logic             start;
  logic             wr_busy;
  logic             tick;
  logic             frame_done;
  logic [DIV_W-1:0] div_q;

  assign start   = wr_stb_i && !busy_o;
  assign wr_busy = wr_stb_i && busy_o;

  avs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_o),
    .div_q (div_q),
    .tick  (tick)
  );

  avs_frame_seq #(.DIV_W(DIV_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .dtype_i      (dtype_i),
    .rail_i       (rail_i),
    .div_i        (div_i),
    .tick_i       (tick),
    .miso_i       (miso_i),
    .div_q        (div_q),
    .busy_o       (busy_o),
    .frame_done_o (frame_done),
    .resp_o       (resp_o),
    .sclk_o       (sclk_o),
    .mosi_o       (mosi_o),
    .cs_n_o       (cs_n_o)
  );

  avs_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_busy),
    .clr_i (clr_sticky_i),
    .err_o (err_o)
  );

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy_o);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_o);
endmodule

// File: tb/tb_avs_frame_master.sv
module tb_avs_frame_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  div_i = '0;
  logic        wr_stb_i = 1'b0;
  logic [3:0]  dtype_i = '0;
  logic [3:0]  rail_i = '0;
  logic        clr_sticky_i = 1'b0;
  logic        miso_i = 1'b0;
  logic        busy_o, err_o, sclk_o, mosi_o, cs_n_o;
  logic [31:0] resp_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  avs_frame_master dut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .wr_stb_i(wr_stb_i),
    .dtype_i(dtype_i), .rail_i(rail_i), .clr_sticky_i(clr_sticky_i),
    .miso_i(miso_i), .busy_o(busy_o), .err_o(err_o), .resp_o(resp_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o)
  );

  // slave model state
  logic [31:0] s_cmd = '0;
  logic [31:0] s_resp = '0;
  int   falls = 0;
  int   cyc = 0;
  int   last_rise = 0;
  int   last_fall = 0;
  int   exp_per = 0;
  int   per_bad = 0;
  int   gap_cyc = 0;
  int   f2_mosi_hi = 0;
  logic sclk_d = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n || cs_n_o) begin
      falls = 0;
    end else begin
      if (sclk_o && !sclk_d) begin
        if (falls > 0 && falls < 32 && (cyc - last_rise) != exp_per)
          per_bad = per_bad + 1;
        if (falls == 32) gap_cyc = cyc - last_fall;
        if (falls >= 32) miso_i = s_resp[63 - falls];
        last_rise = cyc;
      end
      if (!sclk_o && sclk_d) begin
        if (falls < 32) s_cmd = {s_cmd[30:0], mosi_o};
        else if (mosi_o) f2_mosi_hi = f2_mosi_hi + 1;
        falls = falls + 1;
        last_fall = cyc;
      end
    end
    sclk_d = sclk_o;
  end

  function automatic bit [2:0] ref_crc(input bit [31:0] w);
    bit [31:0] v;
    bit [31:0] p;
    v = w & 32'hFFFF_FFF8;
    p = 32'hB000_0000;
    for (int i = 31; i >= 3; i--) begin
      if (v[i]) v = v ^ p;
      p = p >> 1;
    end
    return v[2:0];
  endfunction

  function automatic bit [31:0] ref_cmd(input bit [3:0] dt, input bit [3:0] rl);
    bit [31:0] b;
    b = 32'h7007_FFF8 | (32'(dt) << 23) | (32'(rl) << 19);
    return b | 32'(ref_crc(b));
  endfunction

  task automatic chk(input bit ok, input string req, input bit [31:0] act,
                     input bit [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // mode: 0 plain, 1 strobe while busy, 2 strobe+clear same cycle
  task automatic run_txn(input bit [9:0] dv, input bit [3:0] dt, input bit [3:0] rl,
                         input bit [31:0] rsp, input int mode);
    bit [31:0] expc;
    int wait_n;
    expc = ref_cmd(dt, rl);
    @(negedge clk);
    div_i = dv; dtype_i = dt; rail_i = rl; s_resp = rsp;
    exp_per = (32'(dv) + 1) * 8;
    per_bad = 0; f2_mosi_hi = 0; gap_cyc = 0;
    wr_stb_i = 1'b1;
    @(negedge clk);
    wr_stb_i = 1'b0;
    chk(busy_o && !cs_n_o, "R7 busy/cs up", {30'd0, busy_o, cs_n_o}, 32'h2);
    if (mode != 0) begin
      repeat (40) @(negedge clk);
      dtype_i = ~dt; rail_i = ~rl; wr_stb_i = 1'b1;
      if (mode == 2) clr_sticky_i = 1'b1;
      @(negedge clk);
      wr_stb_i = 1'b0; clr_sticky_i = 1'b0;
      if (mode == 1) chk(err_o, "R8 sticky set", 32'(err_o), 32'd1);
      else chk(err_o, "R9 set wins over clear", 32'(err_o), 32'd1);
    end
    wait_n = 0;
    while (busy_o && wait_n < 50000) begin
      @(negedge clk);
      wait_n = wait_n + 1;
    end
    chk(cs_n_o && !busy_o, "R7 busy/cs down", {30'd0, busy_o, cs_n_o}, 32'h1);
    chk(s_cmd == expc, "R1 command word", s_cmd, expc);
    chk(s_cmd[2:0] == ref_crc(s_cmd), "R2 crc field", 32'(s_cmd[2:0]),
        32'(ref_crc(s_cmd)));
    chk(resp_o == rsp, "R4 response", resp_o, rsp);
    chk(f2_mosi_hi == 0, "R3 mosi low in frame two", 32'(f2_mosi_hi), 32'd0);
    chk(per_bad == 0, "R5 sclk period", 32'(per_bad), 32'd0);
    chk(gap_cyc == (32'(dv) + 1) * 12, "R6 inter-frame gap", 32'(gap_cyc),
        (32'(dv) + 1) * 12);
    chk(!sclk_o, "R5 sclk idle low", 32'(sclk_o), 32'd0);
    repeat (5) @(negedge clk);
    chk(resp_o == rsp, "R4 response held", resp_o, rsp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy_o, "R10 busy", 32'(busy_o), 0);
    chk(!err_o, "R10 err", 32'(err_o), 0);
    chk(resp_o == 0, "R10 resp", resp_o, 0);
    chk(cs_n_o, "R10 cs_n", 32'(cs_n_o), 1);
    chk(!sclk_o, "R10 sclk", 32'(sclk_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // status read word (R1): 0x777FFFF8 before CRC
    run_txn(10'd0, 4'hE, 4'hF, 32'h00A5_5A07, 0);
    chk(s_cmd[31:3] == 29'(32'h777F_FFF8 >> 3), "R1 status body",
        {s_cmd[31:3], 3'b0}, 32'h777F_FFF8);
    run_txn(10'd1, 4'h0, 4'h0, 32'hFFFF_FFFF, 0);
    run_txn(10'd0, 4'hF, 4'h1, 32'h8000_0001, 0);

    // strobe while busy: ignored for the frame, sets sticky (R8)
    run_txn(10'd2, 4'h3, 4'h5, 32'h1234_5678, 1);
    chk(err_o, "R8 sticky persists", 32'(err_o), 1);
    @(negedge clk); clr_sticky_i = 1'b1;
    @(negedge clk); clr_sticky_i = 1'b0;
    chk(!err_o, "R9 clear", 32'(err_o), 0);

    // collision of set and clear (R9)
    run_txn(10'd0, 4'h7, 4'hA, 32'hDEAD_BEEF, 2);
    chk(err_o, "R9 set wins after txn", 32'(err_o), 1);
    @(negedge clk); clr_sticky_i = 1'b1;
    @(negedge clk); clr_sticky_i = 1'b0;
    chk(!err_o, "R9 clear again", 32'(err_o), 0);

    for (int k = 0; k < 8; k++) begin
      run_txn(10'($urandom % 4), 4'($urandom), 4'($urandom), $urandom, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule